// File: doc/BRIEF.md
# Capability Array Walker

This block discovers where a device keeps its status, primary mailbox and memory-device register blocks. It walks a capability array in register space through a simple read-only bus. The walk starts by itself when reset is released and again on every `start` pulse. It first reads the 64-bit array header as two 32-bit reads. It checks that the header identifier is zero and takes the entry count from the header. It then reads an ID word and an offset word for each entry in turn.

Each entry ID is decoded into one of four known kinds. The offsets of three kinds are kept as base outputs. The secondary mailbox only raises a flag. When the walk ends, `done` rises together with a found mask and an error code. The code says whether the array was missing or whether a required block was absent. All results hold until the next start.

Top module: `cap_walker`

## Requirements
- R1: Once reset is released, a walk begins with no `start` pulse. Its first read goes to byte address 0x0. While `rst_n` is low, `busy`, `done`, `found_mask` and `rd_req_valid` are all 0.
- R2: Reads go out one at a time, with at most one outstanding. A request keeps `rd_req_valid` and its address steady until `rd_req_ready` is seen. The address order is 0x0 (header low word), then 0x4 (header high word), then for entry n = 1..count the address n*16 (ID word) followed by n*16+4 (offset word).
- R3: If bits 15:0 of the header low word are not 0, the walk stops after that single read. It raises `done` with `err_code` = 1, and `found_mask` and all bases are 0.
- R4: The entry count is bits 15:0 of the header high word (bits 47:32 of the header). A count of 0 ends the walk with no entry reads, `err_code` = 2 and `found_mask` = 0.
- R5: Bits 15:0 of an entry's ID word select its kind. 0x0001 stores the entry's offset word in `status_base` and sets found bit 0. 0x0002 stores it in `mbox_base` and sets bit 1. 0x4000 stores it in `memdev_base` and sets bit 2. 0x0003 sets bit 3 only and stores no offset. Any other ID changes nothing.
- R6: When an ID occurs more than once, the offset from the later entry replaces the earlier one.
- R7: After the last entry, `err_code` is 0 if found bits 2:0 are all set and 2 otherwise. The zero bits among 2:0 name the missing blocks.
- R8: From the cycle after `start` is sampled in the idle state, `busy` is 1 and `done` is 0. A `start` during a walk is ignored. After `done` rises, `done`, `err_code`, `found_mask` and the bases hold until the next start.
- R9: Every new walk clears `found_mask` and all three bases to 0 before any entry is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new walk when idle |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_addr | output | 32 | Read byte address |
| rd_req_ready | input | 1 | Request accepted |
| rd_rsp_valid | input | 1 | Read data valid (at least one cycle after acceptance) |
| rd_rsp_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, results valid |
| err_code | output | 2 | 0 ok, 1 no array, 2 required block missing |
| found_mask | output | 4 | bit0 status, bit1 primary mailbox, bit2 memory device, bit3 secondary mailbox |
| status_base | output | 32 | Offset of the status block |
| mbox_base | output | 32 | Offset of the primary mailbox block |
| memdev_base | output | 32 | Offset of the memory-device block |

## Verification
The hardest cases to reach are the interplays across entries: a repeated ID whose later offset must win, and a missing block that is hidden behind unknown or secondary IDs. These hinge on the order of IDs within one walk. The stimulus sweeps every ID sequence of length 0 to 3 over six ID values (the four known kinds, an unknown one and zero), with fresh offsets per pattern. The responding bus model varies its acceptance stall and data latency from read to read, so the handshake is exercised in every state of the walk.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int CW_AW         = 32;
  localparam int CW_NKIND      = 4;
  localparam int CW_NKEEP      = 3;
  localparam int CW_STRIDE_LG2 = 4;
  localparam int CW_HI_OFS     = 4;
  localparam int CW_ID_W       = 16;

  localparam logic [CW_ID_W-1:0] CW_ARRAY_ID = 16'h0000;
  // kind order: status, primary mailbox, memory device, secondary mailbox
  localparam logic [CW_ID_W-1:0] CW_KIND_ID [CW_NKIND] =
    '{16'h0001, 16'h0002, 16'h4000, 16'h0003};

  typedef enum logic [1:0] {
    CW_OK      = 2'd0,
    CW_NODEV   = 2'd1,
    CW_MISSING = 2'd2
  } cw_err_e;

  // byte address of entry idx; upper selects the second 32-bit word
  function automatic logic [CW_AW-1:0] cw_slot_addr(input logic [CW_AW-1:0] idx,
                                                    input logic upper);
    return (idx << CW_STRIDE_LG2) | (upper ? CW_AW'(CW_HI_OFS) : '0);
  endfunction

  function automatic cw_err_e cw_verdict(input logic [CW_NKEEP-1:0] have);
    return (&have) ? CW_OK : CW_MISSING;
  endfunction
endpackage

// File: rtl/cw_reader.sv
module cw_reader #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          idle,
  output logic          got,
  output logic [DW-1:0] got_data
);
  typedef enum logic [1:0] {RD_IDLE, RD_ASK, RD_WAIT} rd_st_e;
  rd_st_e        st_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        RD_IDLE: if (go) begin
          addr_q <= go_addr;
          st_q   <= RD_ASK;
        end
        RD_ASK:  if (req_ready) st_q <= RD_WAIT;
        RD_WAIT: if (rsp_valid) st_q <= RD_IDLE;
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == RD_ASK);
  assign req_addr  = addr_q;
  assign idle      = (st_q == RD_IDLE);
  assign got       = (st_q == RD_WAIT) && rsp_valid;
  assign got_data  = rsp_data;

  // R2
  ask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R2
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> idle);
endmodule

// File: rtl/cw_id_decode.sv
module cw_id_decode #(
  parameter int ID_W  = 16,
  parameter int NKIND = 4
) (
  input  logic [ID_W-1:0]  id,
  output logic [NKIND-1:0] hit
);
  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign hit[k] = (id == cw_pkg::CW_KIND_ID[k]);
  end

  // R5
  always_comb begin
    hit_onehot_chk: assert ($onehot0(hit) || $isunknown(id));
  end
endmodule

// File: rtl/cw_base_bank.sv
module cw_base_bank #(
  parameter int AW    = 32,
  parameter int NKEEP = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr_en,
  input  logic [NKEEP-1:0]          sel,
  input  logic [AW-1:0]             wr_data,
  output logic [NKEEP-1:0][AW-1:0]  bases
);
  for (genvar k = 0; k < NKEEP; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr)          bases[k] <= '0;
      else if (wr_en && sel[k])   bases[k] <= wr_data;
    end
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bases == '0));
endmodule

// File: rtl/cap_walker.sv
module cap_walker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_req_valid,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_req_ready,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [3:0]    found_mask,
  output logic [AW-1:0] status_base,
  output logic [AW-1:0] mbox_base,
  output logic [AW-1:0] memdev_base
);
  import cw_pkg::*;
  localparam int NKIND = CW_NKIND;
  localparam int NKEEP = CW_NKEEP;
  localparam int ID_W  = CW_ID_W;

  typedef enum logic [2:0] {S_IDLE, S_HLO, S_HHI, S_EID, S_EOFF} walk_st_e;

  walk_st_e          st_q;
  logic              boot_q, launch_q;
  logic [AW-1:0]     launch_addr_q;
  logic [CNT_W-1:0]  idx_q, cnt_q;
  logic [ID_W-1:0]   id_q;
  logic [NKIND-1:0]  found_q, hit, found_nx;
  cw_err_e           err_q;
  logic              done_q;

  // named internal events
  logic              walk_kick, rd_idle, rd_got, entry_commit, last_entry;
  logic [DW-1:0]     rd_data;
  logic [NKEEP-1:0][AW-1:0] bases;

  assign walk_kick    = (start || boot_q) && (st_q == S_IDLE);
  assign entry_commit = (st_q == S_EOFF) && rd_got;
  assign last_entry   = (idx_q == cnt_q);
  assign found_nx     = found_q | hit;

  cw_reader #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(launch_q), .go_addr(launch_addr_q),
    .req_valid(rd_req_valid), .req_addr(rd_req_addr), .req_ready(rd_req_ready),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .idle(rd_idle), .got(rd_got), .got_data(rd_data));

  cw_id_decode #(.ID_W(ID_W), .NKIND(NKIND)) u_dec (.id(id_q), .hit(hit));

  cw_base_bank #(.AW(AW), .NKEEP(NKEEP)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(walk_kick), .wr_en(entry_commit),
    .sel(hit[NKEEP-1:0]), .wr_data(rd_data[AW-1:0]), .bases(bases));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      boot_q        <= 1'b1;
      launch_q      <= 1'b0;
      launch_addr_q <= '0;
      idx_q         <= '0;
      cnt_q         <= '0;
      id_q          <= '0;
      found_q       <= '0;
      err_q         <= CW_OK;
      done_q        <= 1'b0;
    end else begin
      boot_q   <= 1'b0;
      launch_q <= 1'b0;
      case (st_q)
        S_IDLE: if (walk_kick) begin
          st_q          <= S_HLO;
          launch_q      <= 1'b1;
          launch_addr_q <= AW'(cw_slot_addr('0, 1'b0));
          found_q       <= '0;
          err_q         <= CW_OK;
          done_q        <= 1'b0;
        end
        S_HLO: if (rd_got) begin
          if (rd_data[ID_W-1:0] != CW_ARRAY_ID) begin
            err_q  <= CW_NODEV;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q          <= S_HHI;
            launch_q      <= 1'b1;
            launch_addr_q <= AW'(cw_slot_addr('0, 1'b1));
          end
        end
        S_HHI: if (rd_got) begin
          cnt_q <= rd_data[CNT_W-1:0];
          if (rd_data[CNT_W-1:0] == '0) begin
            err_q  <= cw_verdict(found_q[NKEEP-1:0]);
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            idx_q         <= CNT_W'(1);
            st_q          <= S_EID;
            launch_q      <= 1'b1;
            launch_addr_q <= AW'(cw_slot_addr(CW_AW'(1), 1'b0));
          end
        end
        S_EID: if (rd_got) begin
          id_q          <= rd_data[ID_W-1:0];
          st_q          <= S_EOFF;
          launch_q      <= 1'b1;
          launch_addr_q <= AW'(cw_slot_addr(CW_AW'(idx_q), 1'b1));
        end
        S_EOFF: if (rd_got) begin
          found_q <= found_nx;
          if (last_entry) begin
            err_q  <= cw_verdict(found_nx[NKEEP-1:0]);
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            idx_q         <= idx_q + CNT_W'(1);
            st_q          <= S_EID;
            launch_q      <= 1'b1;
            launch_addr_q <= AW'(cw_slot_addr(CW_AW'(idx_q + CNT_W'(1)), 1'b0));
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign done        = done_q;
  assign err_code    = err_q;
  assign found_mask  = found_q;
  assign status_base = bases[0];
  assign mbox_base   = bases[1];
  assign memdev_base = bases[2];

  // R3
  nodev_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code == 2'd1 |-> found_mask == '0);
  // R7
  ok_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code == 2'd0 |-> &found_mask[NKEEP-1:0]);
  // R7
  missing_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code == 2'd2 |-> !(&found_mask[NKEEP-1:0]));
  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !walk_kick |=> done && $stable(found_mask) && $stable(err_code)
      && $stable(status_base) && $stable(mbox_base) && $stable(memdev_base));
  // R8
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_kick |=> busy && !done);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && rd_idle);
endmodule

// File: tb/cap_walker_tb_top.sv
module cap_walker_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        rd_req_valid, busy, done;
  logic [31:0] rd_req_addr, status_base, mbox_base, memdev_base;
  logic [1:0]  err_code;
  logic [3:0]  found_mask;

  cap_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .done(done), .err_code(err_code), .found_mask(found_mask),
    .status_base(status_base), .mbox_base(mbox_base), .memdev_base(memdev_base));

  int vectors = 0;
  int miscompares = 0;

  logic [15:0] hdr_id, cnt;
  logic [15:0] ids  [1:8];
  logic [31:0] offs [1:8];
  logic [31:0] log_a [0:63];
  int          log_n = 0;
  logic [15:0] idset [6] = '{16'h0001, 16'h0002, 16'h0003, 16'h4000, 16'h0007, 16'h0000};

  logic [1:0]  e_err;
  logic [3:0]  e_found;
  logic [31:0] e_st, e_mb, e_md;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int n;
    if (a == 32'h0) return {16'hC0DE, hdr_id};
    if (a == 32'h4) return {16'h5A5A, cnt};
    n = int'(a >> 4);
    if (n >= 1 && n <= int'(cnt) && n <= 8) begin
      if (a[3:0] == 4'h0) return {16'hBEEF, ids[n]};
      if (a[3:0] == 4'h4) return offs[n];
    end
    return 32'h0;
  endfunction

  // responding bus model: stalls and latency vary per read
  initial begin : slave
    bit have; int wc; int nr; int stall; logic [31:0] la;
    have = 0; wc = 0; nr = 0; stall = 0; la = 0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = 0;
    forever begin
      @(negedge clk);
      rd_req_ready = 0;
      rd_rsp_valid = 0;
      if (!rst_n) have = 0;
      else if (have) begin
        if (wc == 0) begin
          rd_rsp_valid = 1; rd_rsp_data = mem_word(la); have = 0;
        end else wc--;
      end else if (rd_req_valid) begin
        if (stall > 0) stall--;
        else begin
          rd_req_ready = 1; la = rd_req_addr; have = 1; wc = nr % 3;
          if (log_n < 64) log_a[log_n] = la;
          log_n++; nr++; stall = nr % 2;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic calc_expect();
    e_found = 0; e_st = 0; e_mb = 0; e_md = 0;
    if (hdr_id != 16'h0) begin
      e_err = 2'd1;
      return;
    end
    for (int n = 1; n <= int'(cnt); n++) begin
      if (ids[n] == 16'h0001) begin e_found[0] = 1; e_st = offs[n]; end
      else if (ids[n] == 16'h0002) begin e_found[1] = 1; e_mb = offs[n]; end
      else if (ids[n] == 16'h4000) begin e_found[2] = 1; e_md = offs[n]; end
      else if (ids[n] == 16'h0003) e_found[3] = 1;
    end
    e_err = (e_found[2:0] == 3'b111) ? 2'd0 : 2'd2;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    if (!done) chk({tag, " done timeout"}, 32'(done), 32'h1);
  endtask

  task automatic check_results(input string tag);
    int en;
    bit bad = 0;
    int badi = 0;
    calc_expect();
    chk({tag, " done"}, 32'(done), 32'h1);
    chk({tag, " err_code"}, 32'(err_code), 32'(e_err));
    chk({tag, " found_mask"}, 32'(found_mask), 32'(e_found));
    chk({tag, " status_base"}, status_base, e_st);
    chk({tag, " mbox_base"}, mbox_base, e_mb);
    chk({tag, " memdev_base"}, memdev_base, e_md);
    en = (hdr_id != 0) ? 1 : 2 + 2 * int'(cnt);
    chk({tag, " read count"}, 32'(log_n), 32'(en));
    for (int i = 0; i < en && i < log_n && i < 64; i++) begin
      logic [31:0] ea;
      ea = (i < 2) ? 32'(4 * i) : 32'(((i - 2) / 2 + 1) * 16 + ((i % 2) * 4));
      if (!bad && log_a[i] !== ea) begin bad = 1; badi = i; end
    end
    if (bad) begin
      logic [31:0] ea2;
      ea2 = (badi < 2) ? 32'(4 * badi) : 32'(((badi - 2) / 2 + 1) * 16 + ((badi % 2) * 4));
      chk({tag, " read address order"}, log_a[badi], ea2);
    end else chk({tag, " read address order"}, 32'h0, 32'h0);
  endtask

  task automatic run_walk(input string tag);
    log_n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk({tag, " R8 busy after start"}, 32'(busy), 32'h1);
    chk({tag, " R8 done cleared"}, 32'(done), 32'h0);
    wait_done(tag);
    check_results(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    int npat, div;
    rst_n = 0; start = 0;
    hdr_id = 0; cnt = 4;
    ids[1] = 16'h0001; ids[2] = 16'h0002; ids[3] = 16'h4000; ids[4] = 16'h0003;
    for (int n = 1; n <= 8; n++) offs[n] = 32'h0001_0000 * n + 32'h80;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", 32'(busy), 32'h0);
    chk("R1 reset done", 32'(done), 32'h0);
    chk("R1 reset found_mask", 32'(found_mask), 32'h0);
    chk("R1 reset rd_req_valid", 32'(rd_req_valid), 32'h0);
    log_n = 0;
    rst_n = 1;
    // R1 automatic walk after reset
    wait_done("R1");
    check_results("R1 boot walk");

    // R8 outputs hold after done, reads stay quiet
    hdr_id = 16'h0005; cnt = 0;
    repeat (10) @(negedge clk);
    hdr_id = 0; cnt = 4;
    check_results("R8 hold after done");
    chk("R8 no read while idle", 32'(rd_req_valid), 32'h0);

    // R9 bases cleared on new walk; R3 bad header
    hdr_id = 16'h0009; cnt = 3;
    run_walk("R3 R9 bad header");
    hdr_id = 16'h0;

    // R4 zero count
    cnt = 0;
    run_walk("R4 zero count");

    // R6 duplicate IDs: later offset wins
    cnt = 5;
    ids[1] = 16'h0002; ids[2] = 16'h0001; ids[3] = 16'h0002; ids[4] = 16'h4000; ids[5] = 16'h0001;
    for (int n = 1; n <= 5; n++) offs[n] = 32'hD000_0000 + 32'(n * 32'h111);
    run_walk("R6 duplicates");

    // R7 missing memory device behind unknown and secondary IDs
    cnt = 4;
    ids[1] = 16'h0003; ids[2] = 16'h0002; ids[3] = 16'h7777; ids[4] = 16'h0001;
    run_walk("R7 missing block");

    // R8 start during a walk is ignored
    cnt = 3;
    ids[1] = 16'h4000; ids[2] = 16'h0002; ids[3] = 16'h0001;
    log_n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    wait_done("R8 restart ignored");
    check_results("R8 restart ignored");

    // R2 R5 R7 sweep over every ID sequence of length 0..3
    for (int c = 0; c <= 3; c++) begin
      npat = 1;
      for (int k = 0; k < c; k++) npat *= 6;
      for (int p = 0; p < npat; p++) begin
        cnt = 16'(c);
        div = 1;
        for (int n = 1; n <= c; n++) begin
          ids[n]  = idset[(p / div) % 6];
          offs[n] = 32'h1000_0000 + 32'(p * 256) + 32'(n * 16);
          div *= 6;
        end
        run_walk("R2 R5 R7 sweep");
      end
    end

    // longer array with all kinds at the end
    cnt = 8;
    for (int n = 1; n <= 5; n++) ids[n] = 16'h0100 + 16'(n);
    ids[6] = 16'h4000; ids[7] = 16'h0001; ids[8] = 16'h0002;
    for (int n = 1; n <= 8; n++) offs[n] = 32'hA000_0000 | 32'(n);
    run_walk("R5 long array");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule